// File: doc/BRIEF.md
# First-Fault Gather Load Sequencer

This block performs one vector gather load with first-fault semantics. A load is started with an address vector, an immediate offset, a governing byte-granular predicate and an element size. The block walks the elements from lowest to highest. For each active element it issues one read whose address is that element's value plus the immediate. It then waits for the response and places the returned bytes into the destination vector. Inactive elements are skipped without any memory traffic and are left at zero.

A read that comes back with a fault indication does not raise a trap. The load stops at that point, and a first-fault mask records which elements completed. The mask uses the same one-bit-per-byte layout as the predicate: every byte bit from the faulting element's lowest byte upward is cleared, and all bits below it stay true. The mask is reset to all true at the start of each load. It can be read through a separate read strobe that applies no predicate to the value.

The memory side has one outstanding read. A request is held until it is accepted, and a response carries 64 bits of data plus a fault flag. A single-cycle done pulse marks the end of each load.

Top module: `ffgather_seq`

## Requirements
- R1: After reset no request is pending, done is low, the destination vector is zero and a mask read returns all ones.
- R2: Each active element produces exactly one request, in ascending element order. The request address is the element value, zero-extended and truncated to ADDR_W bits, plus the immediate, modulo 2^ADDR_W. The request size code equals the element size code, where codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: Element e occupies bytes e<<size to (e+1)<<size minus one of each vector. There are VBYTES>>size elements. The element is active exactly when predicate bit e<<size is 1. An inactive element issues no request and its destination bytes are zero.
- R4: A non-faulting response writes the low bytes of the response data into the element's destination bytes and leaves the mask unchanged.
- R5: A faulting response at element k clears every mask bit with byte index at or above k<<size and keeps the lower bits. No further request is issued for that load, and destination elements k and higher stay zero.
- R6: Accepting a start sets the mask to all ones across VBYTES bits and clears the destination vector.
- R7: A read strobe sampled at a clock edge makes the read-data output show the mask as it stood before that edge, from the next cycle on. The read is unaffected by the predicate input, and the output holds until the next read strobe.
- R8: done rises for exactly one cycle after the last element has been handled or a fault has been taken. A start asserted while a load is in progress is ignored.
- R9: While a request is not accepted, the request stays valid with a stable address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a load (sampled while idle) |
| base_vec_i | input | VBYTES*8 | Per-element base addresses |
| imm_i | input | ADDR_W | Immediate offset added to every element |
| pred_i | input | VBYTES | Governing predicate, one bit per byte |
| esize_i | input | 2 | Element size code |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Read address |
| mem_req_size_o | output | 2 | Read size code |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | 64 | Response data, element in low bytes |
| mem_rsp_fault_i | input | 1 | Response carries a fault |
| dest_o | output | VBYTES*8 | Assembled destination vector |
| done_o | output | 1 | One-cycle completion pulse |
| ffr_rd_i | input | 1 | Mask read strobe |
| ffr_rd_data_o | output | VBYTES | Mask read data |

## Verification
A mask read and a faulting response can land on the same clock edge, one reading the mask and the other clearing part of it. The bench's memory model raises the read strobe in exactly the cycle in which it returns a faulting response. On the next cycle it requires the read data to be all ones, which is the mask before the clear. A later ordinary read must then show the cleared upper bits. A start that arrives in the middle of a load can also coincide with element processing. It is injected with a different predicate and size, and the results must match the original load only.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } ffg_state_e;

    localparam int MEM_DW = 64;

endpackage

// File: rtl/ffg_elem.sv
module ffg_elem #(
    parameter int VBYTES = 16,
    parameter int ADDR_W = 32,
    localparam int VBITS  = VBYTES * 8,
    localparam int BOFF_W = $clog2(VBYTES),
    localparam int IDX_W  = BOFF_W + 1
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        esz_i,
    input  logic [VBITS-1:0]  base_i,
    input  logic [VBYTES-1:0] pred_i,
    input  logic [ADDR_W-1:0] imm_i,
    output logic              in_range_o,
    output logic              active_o,
    output logic [BOFF_W-1:0] off_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [IDX_W-1:0]  nelem;
    logic [IDX_W+2:0]  shifted;
    logic [BOFF_W+2:0] bpos;
    logic [63:0]       elem_val;

    always_comb begin
        nelem      = IDX_W'(VBYTES) >> esz_i;
        in_range_o = idx_i < nelem;
        shifted    = {3'b000, idx_i} << esz_i;
        off_o      = shifted[BOFF_W-1:0];
        bpos       = {off_o, 3'b000};
        elem_val   = '0;
        if (in_range_o) begin
            case (esz_i)
                2'd0:    elem_val = 64'(base_i[bpos +: 8]);
                2'd1:    elem_val = 64'(base_i[bpos +: 16]);
                2'd2:    elem_val = 64'(base_i[bpos +: 32]);
                default: elem_val = base_i[bpos +: 64];
            endcase
        end
        active_o = in_range_o && pred_i[off_o];
        addr_o   = elem_val[ADDR_W-1:0] + imm_i;
    end
endmodule

// File: rtl/ffg_ffr.sv
module ffg_ffr #(
    parameter int VBYTES = 16,
    localparam int BOFF_W = $clog2(VBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              fault_i,
    input  logic [BOFF_W-1:0] fault_off_i,
    input  logic              rd_i,
    output logic [VBYTES-1:0] rd_data_o
);
    typedef struct packed {
        logic [VBYTES-1:0] mask;
        logic [VBYTES-1:0] rd;
    } ffr_s;

    ffr_s              d, q;
    logic [VBYTES-1:0] clr_vec;

    for (genvar b = 0; b < VBYTES; b++) begin : g_clr
        assign clr_vec[b] = fault_i && (b >= int'(fault_off_i));
    end

    always_comb begin
        d = q;
        if (init_i) begin
            d.mask = '1;
        end else if (fault_i) begin
            d.mask = q.mask & ~clr_vec;
        end
        if (rd_i) begin
            d.rd = q.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mask <= '1;
            q.rd   <= '1;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o = q.rd;

    assert_init_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (&q.mask));

    assert_fault_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !init_i) |=> ((q.mask >> $past(fault_off_i)) == '0));

    assert_mask_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !fault_i) |=> $stable(q.mask));

    assert_read_prior_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (rd_data_o == $past(q.mask)));
endmodule

// File: rtl/ffg_ctrl.sv
module ffg_ctrl
    import ffg_pkg::*;
#(
    parameter int VBYTES = 16,
    parameter int ADDR_W = 32,
    localparam int VBITS  = VBYTES * 8,
    localparam int BOFF_W = $clog2(VBYTES),
    localparam int IDX_W  = BOFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VBITS-1:0]  base_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic [VBYTES-1:0] pred_i,
    input  logic [1:0]        esz_i,
    input  logic              elem_in_range_i,
    input  logic              elem_active_i,
    input  logic [BOFF_W-1:0] elem_off_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic [MEM_DW-1:0] rsp_data_i,
    input  logic              rsp_fault_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [1:0]        esz_o,
    output logic [VBITS-1:0]  base_o,
    output logic [ADDR_W-1:0] imm_o,
    output logic [VBYTES-1:0] pred_o,
    output logic [VBITS-1:0]  dest_o,
    output logic              req_valid_o,
    output logic              done_o,
    output logic              ffr_init_o,
    output logic              fault_o
);
    typedef struct packed {
        ffg_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        esz;
        logic [ADDR_W-1:0] imm;
        logic [VBITS-1:0]  base;
        logic [VBYTES-1:0] pred;
        logic [VBITS-1:0]  dest;
    } ctrl_s;

    ctrl_s             d, q;
    logic [BOFF_W+2:0] bpos;

    always_comb begin
        d           = q;
        req_valid_o = 1'b0;
        done_o      = 1'b0;
        ffr_init_o  = 1'b0;
        fault_o     = 1'b0;
        bpos        = {elem_off_i, 3'b000};
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_ISSUE;
                    d.idx      = '0;
                    d.esz      = esz_i;
                    d.imm      = imm_i;
                    d.base     = base_i;
                    d.pred     = pred_i;
                    d.dest     = '0;
                    ffr_init_o = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (!elem_in_range_i) begin
                    d.st = ST_DONE;
                end else if (!elem_active_i) begin
                    d.idx = q.idx + 1'b1;
                end else begin
                    req_valid_o = 1'b1;
                    if (req_ready_i) begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (rsp_fault_i) begin
                        fault_o = 1'b1;
                        d.st    = ST_DONE;
                    end else begin
                        case (q.esz)
                            2'd0:    d.dest[bpos +: 8]  = rsp_data_i[7:0];
                            2'd1:    d.dest[bpos +: 16] = rsp_data_i[15:0];
                            2'd2:    d.dest[bpos +: 32] = rsp_data_i[31:0];
                            default: d.dest[bpos +: 64] = rsp_data_i;
                        endcase
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_ISSUE;
                    end
                end
            end
            default: begin
                done_o = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign idx_o  = q.idx;
    assign esz_o  = q.esz;
    assign base_o = q.base;
    assign imm_o  = q.imm;
    assign pred_o = q.pred;
    assign dest_o = q.dest;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_stop_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && rsp_valid_i && rsp_fault_i) |=> (!req_valid_o && done_o));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.pred) && $stable(q.esz));
endmodule

// File: rtl/ffgather_seq.sv
module ffgather_seq
    import ffg_pkg::*;
#(
    parameter int VBYTES = 16,
    parameter int ADDR_W = 32,
    localparam int VBITS  = VBYTES * 8,
    localparam int BOFF_W = $clog2(VBYTES),
    localparam int IDX_W  = BOFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VBITS-1:0]  base_vec_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic [VBYTES-1:0] pred_i,
    input  logic [1:0]        esize_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [1:0]        mem_req_size_o,
    input  logic              mem_rsp_valid_i,
    input  logic [MEM_DW-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_fault_i,
    output logic [VBITS-1:0]  dest_o,
    output logic              done_o,
    input  logic              ffr_rd_i,
    output logic [VBYTES-1:0] ffr_rd_data_o
);
    logic [IDX_W-1:0]  idx;
    logic [1:0]        esz;
    logic [VBITS-1:0]  base;
    logic [ADDR_W-1:0] imm;
    logic [VBYTES-1:0] pred;
    logic              in_range, active, ffr_init, fault;
    logic [BOFF_W-1:0] off;

    ffg_elem #(.VBYTES(VBYTES), .ADDR_W(ADDR_W)) u_elem (
        .idx_i      (idx),
        .esz_i      (esz),
        .base_i     (base),
        .pred_i     (pred),
        .imm_i      (imm),
        .in_range_o (in_range),
        .active_o   (active),
        .off_o      (off),
        .addr_o     (mem_req_addr_o)
    );

    ffg_ctrl #(.VBYTES(VBYTES), .ADDR_W(ADDR_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .base_i          (base_vec_i),
        .imm_i           (imm_i),
        .pred_i          (pred_i),
        .esz_i           (esize_i),
        .elem_in_range_i (in_range),
        .elem_active_i   (active),
        .elem_off_i      (off),
        .req_ready_i     (mem_req_ready_i),
        .rsp_valid_i     (mem_rsp_valid_i),
        .rsp_data_i      (mem_rsp_data_i),
        .rsp_fault_i     (mem_rsp_fault_i),
        .idx_o           (idx),
        .esz_o           (esz),
        .base_o          (base),
        .imm_o           (imm),
        .pred_o          (pred),
        .dest_o          (dest_o),
        .req_valid_o     (mem_req_valid_o),
        .done_o          (done_o),
        .ffr_init_o      (ffr_init),
        .fault_o         (fault)
    );

    ffg_ffr #(.VBYTES(VBYTES)) u_ffr (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (ffr_init),
        .fault_i     (fault),
        .fault_off_i (off),
        .rd_i        (ffr_rd_i),
        .rd_data_o   (ffr_rd_data_o)
    );

    assign mem_req_size_o = esz;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_size_o)));
endmodule

// File: tb/ffgather_seq_tb.sv
module ffgather_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VBYTES = 16;
    localparam int ADDR_W = 32;
    localparam int VBITS  = VBYTES * 8;
    localparam int NVEC   = 8;
    localparam logic [4:0] NOFLT = 5'h1F;

    // {fault element, size code, predicate, immediate}
    localparam logic [54:0] VECS [NVEC] = '{
        {NOFLT, 2'd0, 16'hFFFF, 32'h0000_0000},
        {NOFLT, 2'd1, 16'h5555, 32'h0000_0100},
        {5'd3,  2'd2, 16'h1011, 32'h0000_0020},
        {5'd0,  2'd3, 16'h0101, 32'h0000_0008},
        {5'd7,  2'd0, 16'hA5A5, 32'h0000_0007},
        {NOFLT, 2'd1, 16'hAAAA, 32'h0000_0000},
        {5'd2,  2'd2, 16'hFFFF, 32'hFFFF_FFF0},
        {5'd5,  2'd0, 16'hFFDF, 32'h0000_0003}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [VBITS-1:0]  base_vec_i = '0;
    logic [ADDR_W-1:0] imm_i = '0;
    logic [VBYTES-1:0] pred_i = '0;
    logic [1:0]        esize_i = '0;
    logic              mem_req_valid_o;
    logic              mem_req_ready_i = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr_o;
    logic [1:0]        mem_req_size_o;
    logic              mem_rsp_valid_i = 1'b0;
    logic [63:0]       mem_rsp_data_i = '0;
    logic              mem_rsp_fault_i = 1'b0;
    logic [VBITS-1:0]  dest_o;
    logic              done_o;
    logic              rd_main = 1'b0;
    logic              rd_rsp = 1'b0;
    logic              ffr_rd_i;
    logic [VBYTES-1:0] ffr_rd_data_o;

    assign ffr_rd_i = rd_main | rd_rsp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ffgather_seq #(.VBYTES(VBYTES), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_vec_i(base_vec_i),
        .imm_i(imm_i), .pred_i(pred_i), .esize_i(esize_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_req_size_o(mem_req_size_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .mem_rsp_fault_i(mem_rsp_fault_i), .dest_o(dest_o), .done_o(done_o),
        .ffr_rd_i(ffr_rd_i), .ffr_rd_data_o(ffr_rd_data_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] exp_addr [VBYTES];
    int          exp_cnt = 0;
    int          req_seen = 0;
    logic [1:0]  exp_size = '0;
    logic [31:0] fault_addr = '0;
    bit          fault_armed = 0;
    int          rdy_delay = 0;
    int          rsp_lat = 1;

    task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [63:0] elem_value(int e, int seed, logic [1:0] es);
        logic [63:0] v;
        v = {32'hC0DE_0000 | 32'(e), (32'(seed) * 32'h0101_0101) ^ (32'(e) * 32'h0010_0301)};
        if (es != 2'd3) v = v & ((64'd1 << (8 << es)) - 64'd1);
        return v;
    endfunction

    function automatic logic [63:0] mem_data(logic [31:0] a);
        return {~a, a};
    endfunction

    // memory model
    initial begin
        int stall;
        logic [31:0] first_addr;
        logic [1:0]  first_size;
        bit          flt;
        stall = 0;
        first_addr = '0;
        first_size = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid_o) begin
                if (stall == 0) begin
                    first_addr = mem_req_addr_o;
                    first_size = mem_req_size_o;
                end else begin
                    check(mem_req_addr_o == first_addr && mem_req_size_o == first_size,
                          "R9", "held request", {94'd0, mem_req_size_o, mem_req_addr_o},
                          {94'd0, first_size, first_addr});
                end
                if (stall >= rdy_delay) begin
                    stall = 0;
                    mem_req_ready_i = 1'b1;
                    if (req_seen >= exp_cnt) begin
                        check(0, "R5", "request beyond expected", 128'(mem_req_addr_o), 128'(req_seen));
                    end else begin
                        check(mem_req_addr_o == exp_addr[req_seen], "R2", "request address",
                              128'(mem_req_addr_o), 128'(exp_addr[req_seen]));
                        check(mem_req_size_o == exp_size, "R2", "request size",
                              128'(mem_req_size_o), 128'(exp_size));
                    end
                    req_seen++;
                    flt = fault_armed && (mem_req_addr_o == fault_addr);
                    mem_rsp_data_i = mem_data(mem_req_addr_o);
                    @(negedge clk);
                    mem_req_ready_i = 1'b0;
                    repeat (rsp_lat - 1) @(negedge clk);
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_fault_i = flt;
                    rd_rsp = flt;
                    @(negedge clk);
                    mem_rsp_valid_i = 1'b0;
                    mem_rsp_fault_i = 1'b0;
                    if (flt) begin
                        rd_rsp = 1'b0;
                        // read landing on the fault edge sees the mask before the clear
                        check(ffr_rd_data_o == '1, "R7", "read coincident with fault",
                              128'(ffr_rd_data_o), 128'({VBYTES{1'b1}}));
                    end
                end else begin
                    stall++;
                end
            end
        end
    end

    task automatic run_load(int i, logic [54:0] v);
        logic [4:0]        fe;
        logic [1:0]        es;
        logic [15:0]       pr;
        logic [31:0]       im;
        logic [VBITS-1:0]  bv;
        logic [VBITS-1:0]  exp_dest;
        logic [VBYTES-1:0] exp_ffr;
        bit                elem_zero_fault [VBYTES];
        bit                stopped;
        bit                seen_done;
        int                ne;
        int                esz_b;
        int                n;
        fe = v[54:50];
        es = v[49:48];
        pr = v[47:32];
        im = v[31:0];
        ne = VBYTES >> es;
        esz_b = 1 << es;
        bv = '0;
        exp_dest = '0;
        exp_ffr = '1;
        exp_cnt = 0;
        stopped = 0;
        fault_armed = 0;
        for (int e = 0; e < ne; e++) begin
            logic [63:0] ev;
            logic [31:0] a;
            ev = elem_value(e, i * 7 + 3, es);
            for (int b = 0; b < esz_b; b++) bv[(e * esz_b + b) * 8 +: 8] = ev[b * 8 +: 8];
            a = ev[31:0] + im;
            elem_zero_fault[e] = stopped;
            if (!stopped && pr[e * esz_b]) begin
                exp_addr[exp_cnt] = a;
                exp_cnt++;
                if (fe == 5'(e)) begin
                    stopped = 1;
                    elem_zero_fault[e] = 1;
                    fault_armed = 1;
                    fault_addr = a;
                    for (int b = e * esz_b; b < VBYTES; b++) exp_ffr[b] = 1'b0;
                end else begin
                    logic [63:0] md;
                    md = mem_data(a);
                    for (int b = 0; b < esz_b; b++) exp_dest[(e * esz_b + b) * 8 +: 8] = md[b * 8 +: 8];
                end
            end
        end
        exp_size = es;
        req_seen = 0;
        rdy_delay = i % 3;
        rsp_lat = 1 + (i % 2);

        @(negedge clk);
        base_vec_i = bv; imm_i = im; pred_i = pr; esize_i = es; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        seen_done = done_o;
        while (!seen_done && n < 5000) begin
            @(negedge clk);
            n++;
            seen_done = done_o;
            if (!seen_done && i == 4 && n == 3) begin
                // start during a load with other settings must be ignored
                pred_i = 16'hFFFF; esize_i = 2'd1; imm_i = 32'h1234_0000; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                n++;
                seen_done = done_o;
            end
        end
        check(seen_done, "R8", "done reached", 128'(seen_done), 128'd1);
        @(negedge clk);
        check(!done_o, "R8", "done single cycle", 128'(done_o), 128'd0);
        for (int e = 0; e < ne; e++) begin
            string tg;
            if (elem_zero_fault[e]) tg = "R5";
            else if (!pr[e * esz_b]) tg = "R3";
            else tg = "R4";
            check(dest_o[e * esz_b * 8 +: 64 - 0] >> 0 == dest_o[e * esz_b * 8 +: 64] &&
                  (dest_o >> (e * esz_b * 8)) << (VBITS - esz_b * 8) ==
                  (exp_dest >> (e * esz_b * 8)) << (VBITS - esz_b * 8),
                  tg, $sformatf("dest element %0d test %0d", e, i),
                  128'(dest_o), 128'(exp_dest));
        end
        check(req_seen == exp_cnt, (i == 4) ? "R8" : "R3", $sformatf("request count test %0d", i),
              128'(req_seen), 128'(exp_cnt));
        pred_i = '0;
        rd_main = 1'b1;
        @(negedge clk);
        rd_main = 1'b0;
        check(ffr_rd_data_o == exp_ffr, (fe != NOFLT && fault_armed) ? "R5" : "R6",
              $sformatf("mask read test %0d", i), 128'(ffr_rd_data_o), 128'(exp_ffr));
        @(negedge clk);
        check(ffr_rd_data_o == exp_ffr, "R7", "read data held", 128'(ffr_rd_data_o), 128'(exp_ffr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req_valid_o, "R1", "no request after reset", 128'(mem_req_valid_o), 128'd0);
        check(!done_o, "R1", "done low after reset", 128'(done_o), 128'd0);
        check(dest_o == '0, "R1", "dest zero after reset", 128'(dest_o), 128'd0);
        rd_main = 1'b1;
        @(negedge clk);
        rd_main = 1'b0;
        check(ffr_rd_data_o == '1, "R1", "mask after reset", 128'(ffr_rd_data_o), 128'({VBYTES{1'b1}}));

        for (int i = 0; i < NVEC; i++) run_load(i, VECS[i]);

        // directed: all-ones predicate, fault on last doubleword, after a run with faults
        run_load(8, {5'd1, 2'd3, 16'hFFFF, 32'h0000_0040});
        // directed: nothing active at all, mask must be restored to ones
        run_load(9, {NOFLT, 2'd2, 16'h0000, 32'h0000_0000});
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule